// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Control

The block holds two 16-bit down-counting interval timers that share one interrupt controller. Each timer has a 16-bit reload value that software writes one byte at a time, and an 8-bit control byte. The control byte starts and stops the timer, chooses one-shot or free-running operation, can copy the reload value into the counter at once, and can route underflow events to an output pin as a one-clock pulse or as a level that flips on each event. Counting advances only on clocks where the `tickEn` input is high.

The interrupt controller gathers the underflow events of both timers, plus the completion of an 8-step serial shift countdown, into a flag register. A mask register, set and cleared bit by bit through a single address, selects which flags raise the interrupt request. Reading the flag register returns its contents and clears it. Software reaches everything through a small 8-bit register bus with a 4-bit address and separate read and write strobes.

Top module: `dual_interval_timer`

## Requirements
- R1: Address 0 or 2 writes the low byte, and address 1 or 3 the high byte, of the reload value of timer A or B. A high-byte write copies the full reload value into the counter only if the timer's start bit is 0. A low-byte write never changes the counter. Reads of addresses 0 to 3 return the counter's low or high byte.
- R2: Control A is at address 4 and control B at address 5. A timer decrements by one on each clock with `tickEn` high, but only while control bit 0 (start) is 1 and control bit 5 (hold) is 0.
- R3: A tick that finds the counter at zero is an underflow. The counter reloads from the reload value and sets flag bit 0 (timer A) or flag bit 1 (timer B).
- R4: When control bit 3 (one-shot) is 1, an underflow also clears control bit 0, and the timer stops.
- R5: Writing a control byte with bit 4 set copies the reload value into the counter. Bit 4 is never stored and reads back as 0. A control write with bit 4 clear leaves the counter alone.
- R6: With control bit 1 set, underflows of timer A drive `pinA` and underflows of timer B drive `pinB`. With bit 2 clear the pin goes high for the one clock after the underflow. With bit 2 set the pin holds a level that inverts on each underflow, starting from 0 after reset.
- R7: A write to address 7 updates the 5-bit mask. If data bit 7 is 1, the data bits 4:0 that are 1 are set in the mask. If data bit 7 is 0, those same bits are cleared. A flag whose mask bit is 0 never raises the interrupt.
- R8: A read of address 7 returns the flags in bits 4:0, 0 in bits 6:5, and in bit 7 a 1 exactly when some flag is set and also enabled in the mask. The read then clears all flags. An event in the same clock as the read survives.
- R9: A write to address 6 stores a serial data byte, which reads back at address 6, and loads a countdown of 8. While control A bit 6 is 1, each tick lowers the countdown, and the tick that takes it from 1 to 0 sets flag bit 3.
- R10: `irqOut` is high while flag-read bit 7 would read 1. It is low on the clock after a flag read that has no new event.
- R11: After reset, both counters, both reload values, both control bytes, the serial data, the mask, all flags and both pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe; a flag read clears the flags |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid while regRd is high, 0 otherwise |
| tickEn | input | 1 | Count-enable tick |
| irqOut | output | 1 | Interrupt request |
| pinA | output | 1 | Timer A underflow pin |
| pinB | output | 1 | Timer B underflow pin |

## Verification
The embedded properties assume that register strobes last one clock. They also assume that when a reload or one-shot check is made, no control write or high-byte write falls in the same clock as an underflow, because those writes take priority over the tick path. The stimulus keeps `tickEn` low during every bus access and raises it only in separate counting phases. Reads of the flag register are likewise issued only when no timer or serial event can occur in that clock, so the clear-on-read behaviour is seen on its own.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int DATA_W  = 8;
  parameter int ADDR_W  = 4;
  parameter int CNT_W   = 2 * DATA_W;
  parameter int N_TMR   = 2;
  parameter int FLAG_W  = 5;
  parameter int SHIFT_LEN = 8;
  localparam int SHIFT_W = $clog2(SHIFT_LEN + 1);

  // control byte bit positions
  localparam int CB_START   = 0;
  localparam int CB_PIN     = 1;
  localparam int CB_TOGGLE  = 2;
  localparam int CB_ONESHOT = 3;
  localparam int CB_FORCE   = 4;
  localparam int CB_HOLD    = 5;
  localparam int CB_SERIAL  = 6;

  // flag positions and mask write mode bit
  localparam int FLAG_SERIAL = 3;
  localparam int MASK_SETBIT = 7;

  // register addresses
  localparam int ADDR_CTRL_BASE = 2 * N_TMR;
  localparam int ADDR_SERIAL    = ADDR_CTRL_BASE + N_TMR;
  localparam int ADDR_FLAG      = ADDR_SERIAL + 1;

  typedef struct packed {
    logic [N_TMR-1:0] latchLoWr;
    logic [N_TMR-1:0] latchHiWr;
    logic [N_TMR-1:0] ctrlWr;
    logic             serialWr;
    logic             maskWr;
    logic             flagRd;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWr,
  input  logic                          regRd,
  input  logic [N_TMR-1:0][CNT_W-1:0]   cntVal,
  input  logic [N_TMR-1:0][DATA_W-1:0]  ctrlVal,
  input  logic [DATA_W-1:0]             serialData,
  input  logic [DATA_W-1:0]             flagByte,
  output tmrStrobe_t                    strobe,
  output logic [DATA_W-1:0]             regRdata
);
  for (genvar i = 0; i < N_TMR; i++) begin : g_dec
    assign strobe.latchLoWr[i] = regWr && (regAddr == ADDR_W'(2 * i));
    assign strobe.latchHiWr[i] = regWr && (regAddr == ADDR_W'(2 * i + 1));
    assign strobe.ctrlWr[i]    = regWr && (regAddr == ADDR_W'(ADDR_CTRL_BASE + i));
  end
  assign strobe.serialWr = regWr && (regAddr == ADDR_W'(ADDR_SERIAL));
  assign strobe.maskWr   = regWr && (regAddr == ADDR_W'(ADDR_FLAG));
  assign strobe.flagRd   = regRd && (regAddr == ADDR_W'(ADDR_FLAG));

  always_comb begin
    regRdata = '0;
    if (regRd) begin
      for (int i = 0; i < N_TMR; i++) begin
        if (regAddr == ADDR_W'(2 * i))              regRdata = cntVal[i][DATA_W-1:0];
        if (regAddr == ADDR_W'(2 * i + 1))          regRdata = cntVal[i][CNT_W-1:DATA_W];
        if (regAddr == ADDR_W'(ADDR_CTRL_BASE + i)) regRdata = ctrlVal[i];
      end
      if (regAddr == ADDR_W'(ADDR_SERIAL)) regRdata = serialData;
      if (regAddr == ADDR_W'(ADDR_FLAG))   regRdata = flagByte;
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              latchLoWr,
  input  logic              latchHiWr,
  input  logic              ctrlWr,
  output logic [CNT_W-1:0]  cntOut,
  output logic [DATA_W-1:0] ctrlOut,
  output logic              underflow,
  output logic              pinOut
);
  localparam logic [DATA_W-1:0] FORCE_MASK = DATA_W'(1) << CB_FORCE;

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  latchQ;
  logic [DATA_W-1:0] ctrlQ;
  logic              pulseQ;
  logic              togQ;
  logic              running;

  assign running   = ctrlQ[CB_START] && !ctrlQ[CB_HOLD];
  assign underflow = tickEn && running && (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ   <= '0;
      latchQ <= '0;
      ctrlQ  <= '0;
      pulseQ <= 1'b0;
      togQ   <= 1'b0;
    end else begin
      pulseQ <= underflow;
      if (underflow) togQ <= ~togQ;
      if (latchLoWr) latchQ[DATA_W-1:0]     <= wdata;
      if (latchHiWr) latchQ[CNT_W-1:DATA_W] <= wdata;
      if (ctrlWr)
        ctrlQ <= wdata & ~FORCE_MASK;
      else if (underflow && ctrlQ[CB_ONESHOT])
        ctrlQ[CB_START] <= 1'b0;
      if (ctrlWr && wdata[CB_FORCE])
        cntQ <= latchQ;
      else if (latchHiWr && !ctrlQ[CB_START])
        cntQ <= {wdata, latchQ[DATA_W-1:0]};
      else if (underflow)
        cntQ <= latchQ;
      else if (tickEn && running)
        cntQ <= cntQ - 1'b1;
    end
  end

  assign cntOut  = cntQ;
  assign ctrlOut = ctrlQ;
  assign pinOut  = ctrlQ[CB_PIN] && (ctrlQ[CB_TOGGLE] ? togQ : pulseQ);

  // R2: a plain tick lowers the count by exactly one
  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && running && cntQ != '0 && !ctrlWr && !latchHiWr) |=> (cntQ == $past(cntQ) - 1'b1));
  // R3: an underflow reloads from the reload value
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !ctrlWr && !latchHiWr) |=> (cntQ == $past(latchQ)));
  // R4: one-shot underflow stops the timer
  assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && ctrlQ[CB_ONESHOT] && !ctrlWr) |=> !ctrlQ[CB_START]);
  // R6: pulse mode pin is high after an underflow
  assert_pulse_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && ctrlQ[CB_PIN] && !ctrlQ[CB_TOGGLE] && !ctrlWr) |=> pinOut);
endmodule

// File: rtl/tmr_intr.sv
module tmr_intr
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              serialWr,
  input  logic              maskWr,
  input  logic              flagRd,
  input  logic              serialEn,
  input  logic [N_TMR-1:0]  underflow,
  output logic [DATA_W-1:0] serialData,
  output logic [DATA_W-1:0] flagByte,
  output logic              irqOut
);
  logic [DATA_W-1:0]  sdrQ;
  logic [SHIFT_W-1:0] shiftCntQ;
  logic [FLAG_W-1:0]  flagsQ;
  logic [FLAG_W-1:0]  maskQ;
  logic [FLAG_W-1:0]  setVec;
  logic               serialDone;
  logic               pending;

  assign serialDone = tickEn && serialEn && (shiftCntQ == SHIFT_W'(1));

  always_comb begin
    setVec = '0;
    setVec[N_TMR-1:0]   = underflow;
    setVec[FLAG_SERIAL] = serialDone;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdrQ      <= '0;
      shiftCntQ <= '0;
      flagsQ    <= '0;
      maskQ     <= '0;
    end else begin
      if (serialWr) begin
        sdrQ      <= wdata;
        shiftCntQ <= SHIFT_W'(SHIFT_LEN);
      end else if (tickEn && serialEn && shiftCntQ != '0) begin
        shiftCntQ <= shiftCntQ - 1'b1;
      end
      flagsQ <= (flagRd ? '0 : flagsQ) | setVec;
      if (maskWr) begin
        if (wdata[MASK_SETBIT]) maskQ <= maskQ | wdata[FLAG_W-1:0];
        else                    maskQ <= maskQ & ~wdata[FLAG_W-1:0];
      end
    end
  end

  assign pending    = |(flagsQ & maskQ);
  assign flagByte   = {pending, {(DATA_W-FLAG_W-1){1'b0}}, flagsQ};
  assign serialData = sdrQ;
  assign irqOut     = pending;

  // R7: set-mode mask write enables the written bits
  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (maskWr && wdata[MASK_SETBIT]) |=> ((maskQ & $past(wdata[FLAG_W-1:0])) == $past(wdata[FLAG_W-1:0])));
  // R7: clear-mode mask write disables the written bits
  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (maskWr && !wdata[MASK_SETBIT]) |=> ((maskQ & $past(wdata[FLAG_W-1:0])) == '0));
  // R9: finishing the serial countdown raises its flag
  assert_serial_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    serialDone |=> flagsQ[FLAG_SERIAL]);
  // R10: a flag read with no new event drops the request
  assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flagRd && setVec == '0) |=> !irqOut);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              tickEn,
  output logic              irqOut,
  output logic              pinA,
  output logic              pinB
);
  tmrStrobe_t                   strobe;
  logic [N_TMR-1:0][CNT_W-1:0]  cntVal;
  logic [N_TMR-1:0][DATA_W-1:0] ctrlVal;
  logic [N_TMR-1:0]             underflow;
  logic [N_TMR-1:0]             pins;
  logic [DATA_W-1:0]            serialData;
  logic [DATA_W-1:0]            flagByte;

  tmr_ctrl ctrl_i (
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .cntVal(cntVal), .ctrlVal(ctrlVal), .serialData(serialData),
    .flagByte(flagByte), .strobe(strobe), .regRdata(regRdata)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    tmr_unit unit_i (
      .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wdata(regWdata),
      .latchLoWr(strobe.latchLoWr[i]), .latchHiWr(strobe.latchHiWr[i]),
      .ctrlWr(strobe.ctrlWr[i]), .cntOut(cntVal[i]), .ctrlOut(ctrlVal[i]),
      .underflow(underflow[i]), .pinOut(pins[i])
    );
  end

  tmr_intr intr_i (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wdata(regWdata),
    .serialWr(strobe.serialWr), .maskWr(strobe.maskWr), .flagRd(strobe.flagRd),
    .serialEn(ctrlVal[0][CB_SERIAL]), .underflow(underflow),
    .serialData(serialData), .flagByte(flagByte), .irqOut(irqOut)
  );

  assign pinA = pins[0];
  assign pinB = pins[1];
endmodule

// File: tb/dual_interval_timer_tb_top.sv
module dual_interval_timer_tb_top;
  localparam int K_RD = 0, K_IRQ = 1, K_PA = 2, K_PB = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       tickEn = 1'b0;
  logic       irqOut, pinA, pinB;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t expQ[$];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dual_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .tickEn(tickEn),
    .irqOut(irqOut), .pinA(pinA), .pinB(pinB)
  );

  task automatic push(input int kind, input logic [7:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    push(K_RD, exp, req);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = expQ.pop_front();
        case (it.kind)
          K_RD:    act = regRdata;
          K_IRQ:   act = {7'd0, irqOut};
          K_PA:    act = {7'd0, pinA};
          default: act = {7'd0, pinB};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    // R11 reset state
    rd(4'd0, 8'h00, "R11 cntA lo");
    rd(4'd3, 8'h00, "R11 cntB hi");
    rd(4'd4, 8'h00, "R11 ctrlA");
    rd(4'd6, 8'h00, "R11 serial");
    rd(4'd7, 8'h00, "R11 flags");
    push(K_IRQ, 8'h00, "R11 irq"); push(K_PA, 8'h00, "R11 pinA"); push(K_PB, 8'h00, "R11 pinB");

    // R1 load while stopped
    wr(4'd0, 8'h05); wr(4'd1, 8'h00);
    rd(4'd0, 8'h05, "R1 stopped high write loads");
    // R2 hold bit blocks counting
    wr(4'd4, 8'h21); tick(3);
    rd(4'd0, 8'h05, "R2 hold bit stops count");
    wr(4'd4, 8'h01); tick(3);
    rd(4'd0, 8'h02, "R2 decrement");
    rd(4'd4, 8'h01, "R5 ctrl readback");
    wr(4'd1, 8'h00);
    rd(4'd0, 8'h02, "R1 running high write no load");
    // R3 underflow
    tick(3);
    rd(4'd0, 8'h05, "R3 reload");
    push(K_IRQ, 8'h00, "R7 masked flag no irq");
    rd(4'd7, 8'h01, "R3 flag A");
    rd(4'd7, 8'h00, "R8 read clears");
    wr(4'd4, 8'h00);
    // R7 mask set then clear
    wr(4'd7, 8'h83); wr(4'd7, 8'h02);
    // R4 + R6 pulse
    wr(4'd0, 8'h02); wr(4'd1, 8'h00);
    wr(4'd4, 8'h0B); tick(3);
    push(K_PA, 8'h01, "R6 pulse high");
    push(K_IRQ, 8'h01, "R10 irq on enabled flag");
    idle(1);
    push(K_PA, 8'h00, "R6 pulse one clock");
    rd(4'd4, 8'h0A, "R4 oneshot stop");
    rd(4'd0, 8'h02, "R3 oneshot reload");
    tick(2);
    rd(4'd0, 8'h02, "R4 stopped no count");
    rd(4'd7, 8'h81, "R8 pending bit");
    push(K_IRQ, 8'h00, "R10 irq drops after read");
    // R6 toggle on timer B
    wr(4'd2, 8'h01); wr(4'd3, 8'h00);
    wr(4'd5, 8'h07); tick(2);
    push(K_PB, 8'h01, "R6 toggle high");
    idle(1);
    push(K_PB, 8'h01, "R6 toggle holds");
    push(K_IRQ, 8'h00, "R7 cleared mask bit");
    tick(2);
    push(K_PB, 8'h00, "R6 toggle back");
    rd(4'd7, 8'h02, "R3 flag B");
    wr(4'd5, 8'h00);
    wr(4'd2, 8'h34); wr(4'd3, 8'h12);
    rd(4'd2, 8'h34, "R1 cntB lo");
    rd(4'd3, 8'h12, "R1 cntB hi");
    // R5 forced reload
    wr(4'd0, 8'h40);
    rd(4'd0, 8'h02, "R1 low write no load");
    wr(4'd4, 8'h10);
    rd(4'd0, 8'h40, "R5 forced reload");
    rd(4'd4, 8'h00, "R5 bit4 reads zero");
    // R9 serial countdown
    wr(4'd7, 8'h88);
    wr(4'd4, 8'h40);
    wr(4'd6, 8'hA5);
    rd(4'd6, 8'hA5, "R9 serial readback");
    tick(7);
    push(K_IRQ, 8'h00, "R9 not yet done");
    tick(1);
    push(K_IRQ, 8'h01, "R9 done raises irq");
    rd(4'd7, 8'h88, "R8 serial flag read");
    push(K_IRQ, 8'h00, "R10 irq cleared");
    wr(4'd7, 8'h08);
    wr(4'd6, 8'h3C); tick(8);
    push(K_IRQ, 8'h00, "R7 serial masked");
    rd(4'd7, 8'h08, "R8 unmasked flag no bit7");
    rd(4'd0, 8'h40, "R2 start clear no count");
    idle(3);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule